// File: doc/BRIEF.md
# Debug Line Abort and Acknowledge Controller

This block sits on the target end of a single-wire, open-drain debug line. It follows the handshake of each host command from the first falling edge through execution to the acknowledge. When a command completes, the block pulls the line low for a fixed number of serial clock cycles to acknowledge it.

The block also measures every low pulse the host drives and sorts it into one of three kinds:
- a long pulse, which is a resynchronisation request;
- a medium pulse, which aborts the pending command;
- a short glitch, which is ignored.

When an abort arrives, the block cancels the acknowledge. It cancels the command itself only when the command is a memory access that has not started yet. Run-type commands and accesses already under way keep going.

A bit-level command decoder feeds this block. The decoder reports when a full command has arrived, whether the command is run-type, and whether its memory access has begun. The CPU low-power status is also an input: a command that arrives while the CPU is in wait or stop is dropped, and no acknowledge is ever issued for it. The acknowledge has no timeout, and a second command cannot be accepted while an acknowledge is outstanding. Only an abort or a resync frees the block.

Top module: `dbgw_abort_ctl`

## Requirements
- R1: After reset the block is idle with no acknowledge outstanding: every strobe output and `ack_drive_o` are 0.
- R2: In idle, a falling edge of the line gives exactly one `cmd_start_o` strobe, and the block moves into command reception.
- R3: A host low pulse of at least SYNC_LEN (128) cycles, ending while the block is not driving an acknowledge, gives a `sync_req_o` strobe and returns the block to idle. If an acknowledge was outstanding, `ack_abort_o` is also strobed. Falling edges during reception give no `cmd_start_o`.
- R4: The low-pulse width saturates, so a 300-cycle pulse is still classified as a resync and never as a short abort.
- R5: With an acknowledge outstanding, a low pulse of MIN_ABORT (4) to 127 cycles strobes `ack_abort_o` without `sync_req_o` and returns the block to idle. The next falling edge then strobes `cmd_start_o`.
- R6: With an acknowledge outstanding, a low pulse shorter than 4 cycles changes nothing: there is no strobe, and a later completion still produces the acknowledge.
- R7: An abort of a run-type command (`cmd_run_i`=1 at acceptance) strobes `ack_abort_o` but not `cmd_kill_o`. An abort of a memory command whose access has not begun strobes both.
- R8: If `mem_busy_i` was seen high while the command was outstanding, an abort strobes `ack_abort_o` but not `cmd_kill_o`.
- R9: A command accepted while `cpu_sleep_i`=1 is discarded. `exec_done_i` then produces no acknowledge, and the block stays outstanding until an abort.
- R10: `exec_done_i` on an outstanding live command drives `ack_drive_o` high for exactly ACK_LEN (16) cycles, after which the block is idle.
- R11: Acknowledges do not nest. While a command is outstanding, falling edges give no `cmd_start_o` and `cmd_valid_i` is ignored.
- R12: Falling edges while `ack_drive_o` is high are masked. A host pulse that collides with the acknowledge gives neither `cmd_start_o` nor `ack_abort_o`.
- R13: `cmd_start_o`, `sync_req_o`, `ack_abort_o` and `cmd_kill_o` are each high for a single cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Debug line level, asynchronous; synchronised inside the block |
| cmd_valid_i | input | 1 | Strobe from the decoder: a complete command has been received |
| cmd_run_i | input | 1 | Command being accepted is run-type (go, step, go-until) |
| cpu_sleep_i | input | 1 | CPU is in wait or stop |
| mem_busy_i | input | 1 | Memory access of the outstanding command has begun |
| exec_done_i | input | 1 | Strobe: the outstanding command has finished executing |
| cmd_start_o | output | 1 | Strobe: a falling edge opened a new command |
| sync_req_o | output | 1 | Strobe: a resync pulse was recognised |
| ack_abort_o | output | 1 | Strobe: the outstanding acknowledge was cancelled |
| cmd_kill_o | output | 1 | Strobe: execution of the outstanding command is cancelled |
| ack_drive_o | output | 1 | High while the block pulls the line low to acknowledge |

## Verification
The assertions assume that `cmd_valid_i` and `exec_done_i` are single-cycle strobes. They also assume `cmd_valid_i` arrives only after a command start has been seen, and that the line seen by the block is the wired-AND of the host level and the block's own acknowledge drive. The bench models the line exactly as that AND. It issues each decoder strobe as a one-cycle pulse after a start pulse has put the block into reception. Between scenarios it holds the line high long enough for each classification to settle.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_PEND = 2'd2,
    ST_ACK  = 2'd3
  } dbgw_state_e;

  typedef enum logic [1:0] {
    PW_GLITCH = 2'd0,
    PW_SHORT  = 2'd1,
    PW_SYNC   = 2'd2
  } pw_kind_e;

  // Sort a measured low width into glitch, short abort or resync.
  function automatic pw_kind_e classify_width(input int unsigned width,
                                              input int unsigned sync_len,
                                              input int unsigned min_abort);
    if (width >= sync_len)       return PW_SYNC;
    else if (width >= min_abort) return PW_SHORT;
    else                         return PW_GLITCH;
  endfunction

endpackage

// File: rtl/dbgw_line_sync.sv
module dbgw_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_s,
  output logic fall_e,
  output logic rise_e
);
  logic [1:0] sync_ff;
  logic       prev_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_ff <= 2'b11;
      prev_s  <= 1'b1;
    end else begin
      sync_ff <= {sync_ff[0], line_raw};
      prev_s  <= sync_ff[1];
    end
  end

  assign line_s = sync_ff[1];
  assign fall_e = prev_s & ~line_s;
  assign rise_e = ~prev_s & line_s;
endmodule

// File: rtl/dbgw_low_timer.sv
module dbgw_low_timer #(
  parameter int unsigned SAT = 128,
  localparam int unsigned W = $clog2(SAT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_s,
  input  logic         fall_e,
  output logic [W-1:0] width
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             width <= '0;
    else if (fall_e)                        width <= W'(1);
    else if (!line_s && width != W'(SAT))   width <= width + W'(1);
  end
endmodule

// File: rtl/dbgw_ack_timer.sv
module dbgw_ack_timer #(
  parameter int unsigned LEN = 16,
  localparam int unsigned W = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic drive,
  output logic last
);
  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (go)             remain <= W'(LEN);
    else if (remain != '0)   remain <= remain - W'(1);
  end

  assign drive = (remain != '0);
  assign last  = (remain == W'(1));
endmodule

// File: rtl/dbgw_abort_ctl.sv
module dbgw_abort_ctl
  import dbgw_pkg::*;
#(
  parameter int unsigned SYNC_LEN  = 128,
  parameter int unsigned MIN_ABORT = 4,
  parameter int unsigned ACK_LEN   = 16,
  localparam int unsigned LW = $clog2(SYNC_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic cmd_valid_i,
  input  logic cmd_run_i,
  input  logic cpu_sleep_i,
  input  logic mem_busy_i,
  input  logic exec_done_i,
  output logic cmd_start_o,
  output logic sync_req_o,
  output logic ack_abort_o,
  output logic cmd_kill_o,
  output logic ack_drive_o
);
  dbgw_state_e state;
  logic          line_s, fall_e, rise_e;
  logic [LW-1:0] low_w;
  pw_kind_e      pw_kind;
  logic          run_q, acc_q, doomed_q;
  logic          ack_go, ack_last;
  logic          ev_sync, ev_short, ev_start, ev_abort, kill_now;

  dbgw_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_raw(line_in),
    .line_s(line_s), .fall_e(fall_e), .rise_e(rise_e)
  );

  dbgw_low_timer #(.SAT(SYNC_LEN)) u_low (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .fall_e(fall_e), .width(low_w)
  );

  dbgw_ack_timer #(.LEN(ACK_LEN)) u_ack (
    .clk(clk), .rst_n(rst_n), .go(ack_go), .drive(ack_drive_o), .last(ack_last)
  );

  assign pw_kind  = classify_width(32'(low_w), SYNC_LEN, MIN_ABORT);
  assign ev_sync  = rise_e && (state != ST_ACK) && (pw_kind == PW_SYNC);
  assign ev_short = rise_e && (state == ST_PEND) && (pw_kind == PW_SHORT);
  assign ev_start = fall_e && (state == ST_IDLE);
  assign ev_abort = (state == ST_PEND) && (ev_sync || ev_short);
  assign kill_now = ev_abort && !run_q && !acc_q && !doomed_q;
  assign ack_go   = (state == ST_PEND) && exec_done_i && !doomed_q
                    && !ev_sync && !ev_short;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      run_q    <= 1'b0;
      acc_q    <= 1'b0;
      doomed_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (ev_start) state <= ST_RECV;
        ST_RECV: begin
          if (ev_sync) state <= ST_IDLE;
          else if (cmd_valid_i) begin
            state    <= ST_PEND;
            run_q    <= cmd_run_i;
            doomed_q <= cpu_sleep_i;
            acc_q    <= 1'b0;
          end
        end
        ST_PEND: begin
          if (ev_abort)        state <= ST_IDLE;
          else if (ack_go)     state <= ST_ACK;
          if (mem_busy_i)      acc_q <= 1'b1;
        end
        ST_ACK:  if (ack_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_start_o <= 1'b0;
      sync_req_o  <= 1'b0;
      ack_abort_o <= 1'b0;
      cmd_kill_o  <= 1'b0;
    end else begin
      cmd_start_o <= ev_start;
      sync_req_o  <= ev_sync;
      ack_abort_o <= ev_abort;
      cmd_kill_o  <= kill_now;
    end
  end
endmodule

// File: rtl/dbgw_abort_chk.sv
module dbgw_abort_chk #(
  parameter int unsigned ACK_LEN = 16
) (
  input logic clk,
  input logic rst_n,
  input logic ev_sync,
  input logic ev_abort,
  input logic cmd_start_o,
  input logic sync_req_o,
  input logic ack_abort_o,
  input logic cmd_kill_o,
  input logic ack_drive_o
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_len <= '0;
    else if (ack_drive_o) run_len <= run_len + 16'd1;
    else                  run_len <= '0;
  end

  a_r13_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start_o |=> !cmd_start_o);
  a_r13_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req_o |=> !sync_req_o);
  a_r13_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_abort_o |=> !ack_abort_o);
  a_r7_kill_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_kill_o |-> ack_abort_o);
  a_r10_ack_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_drive_o) |-> (run_len == 16'(ACK_LEN)));
  a_r12_quiet_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drive_o |-> !(cmd_start_o || ack_abort_o || cmd_kill_o));
  a_r3_sync_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req_o |-> !cmd_start_o);
  a_r3_sync_reported: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> sync_req_o);
  a_r5_abort_reported: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (ack_abort_o && !ack_drive_o));
endmodule

bind dbgw_abort_ctl dbgw_abort_chk #(.ACK_LEN(ACK_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_sync(ev_sync), .ev_abort(ev_abort),
  .cmd_start_o(cmd_start_o), .sync_req_o(sync_req_o),
  .ack_abort_o(ack_abort_o), .cmd_kill_o(cmd_kill_o),
  .ack_drive_o(ack_drive_o)
);

// File: tb/sim_dbgw_abort_ctl.sv
module sim_dbgw_abort_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int ACK_CYC    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_lvl = 1'b1;
  logic cmd_valid = 1'b0, cmd_run = 1'b0, cpu_sleep = 1'b0;
  logic mem_busy = 1'b0, exec_done = 1'b0;
  logic cmd_start, sync_req, ack_abort, cmd_kill, ack_drive;
  logic line;

  int n_tests = 0, n_fail = 0;
  int c_start = 0, c_sync = 0, c_abort = 0, c_kill = 0, c_ackcyc = 0, c_ack = 0;
  int s_start, s_sync, s_abort, s_kill, s_ackcyc, s_ack;
  logic prev_drive = 1'b0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain line: low when host or target pulls it low
  assign line = host_lvl & ~ack_drive;

  dbgw_abort_ctl u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line),
    .cmd_valid_i(cmd_valid), .cmd_run_i(cmd_run), .cpu_sleep_i(cpu_sleep),
    .mem_busy_i(mem_busy), .exec_done_i(exec_done),
    .cmd_start_o(cmd_start), .sync_req_o(sync_req), .ack_abort_o(ack_abort),
    .cmd_kill_o(cmd_kill), .ack_drive_o(ack_drive)
  );

  always @(negedge clk) begin
    if (cmd_start) c_start++;
    if (sync_req)  c_sync++;
    if (ack_abort) c_abort++;
    if (cmd_kill)  c_kill++;
    if (ack_drive) c_ackcyc++;
    if (ack_drive && !prev_drive) c_ack++;
    prev_drive = ack_drive;
  end

  task automatic summary_and_end();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      summary_and_end();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic snap();
    s_start = c_start; s_sync = c_sync; s_abort = c_abort;
    s_kill = c_kill; s_ackcyc = c_ackcyc; s_ack = c_ack;
  endtask

  task automatic low_pulse(input int n);
    @(negedge clk) host_lvl = 1'b0;
    repeat (n) @(negedge clk);
    host_lvl = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_cmd(input logic run, input logic sleep);
    low_pulse(2);
    @(negedge clk) begin cmd_valid = 1'b1; cmd_run = run; cpu_sleep = sleep; end
    @(negedge clk) begin cmd_valid = 1'b0; cmd_run = 1'b0; cpu_sleep = 1'b0; end
  endtask

  task automatic pulse_done();
    @(negedge clk) exec_done = 1'b1;
    @(negedge clk) exec_done = 1'b0;
  endtask

  task automatic go_idle();
    repeat (24) @(negedge clk);
    low_pulse(140);
    snap();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 strobes", int'(cmd_start | sync_req | ack_abort | cmd_kill), 0);
    chk("R1 ack_drive", int'(ack_drive), 0);
  endtask

  task automatic t_start_and_sync();
    snap();
    low_pulse(3);
    chk("R2 start", c_start - s_start, 1);
    low_pulse(3);            // bit inside reception: no new start
    chk("R3 recv no start", c_start - s_start, 1);
    low_pulse(130);
    chk("R3 sync", c_sync - s_sync, 1);
    chk("R3 no abort idle", c_abort - s_abort, 0);
  endtask

  task automatic t_ack();
    go_idle();
    send_cmd(1'b0, 1'b0);
    pulse_done();
    repeat (30) @(negedge clk);
    chk("R10 ack count", c_ack - s_ack, 1);
    chk("R10 ack width", c_ackcyc - s_ackcyc, ACK_CYC);
    low_pulse(2);
    chk("R10 idle after ack", c_start - s_start, 2);
  endtask

  task automatic t_short_abort();
    go_idle();
    send_cmd(1'b0, 1'b0);
    low_pulse(10);
    chk("R5 abort", c_abort - s_abort, 1);
    chk("R7 kill mem cmd", c_kill - s_kill, 1);
    chk("R5 no sync", c_sync - s_sync, 0);
    chk("R13 abort one cycle", c_abort - s_abort, 1);
    low_pulse(2);
    chk("R5 next edge starts", c_start - s_start, 2);
  endtask

  task automatic t_run_abort();
    go_idle();
    send_cmd(1'b1, 1'b0);
    low_pulse(10);
    chk("R7 run abort", c_abort - s_abort, 1);
    chk("R7 run no kill", c_kill - s_kill, 0);
    pulse_done();
    repeat (20) @(negedge clk);
    chk("R7 no ack after abort", c_ack - s_ack, 0);
  endtask

  task automatic t_mem_begun();
    go_idle();
    send_cmd(1'b0, 1'b0);
    @(negedge clk) mem_busy = 1'b1;
    @(negedge clk) mem_busy = 1'b0;
    low_pulse(8);
    chk("R8 abort", c_abort - s_abort, 1);
    chk("R8 no kill", c_kill - s_kill, 0);
  endtask

  task automatic t_glitch();
    go_idle();
    send_cmd(1'b0, 1'b0);
    low_pulse(3);
    chk("R6 no abort", c_abort - s_abort, 0);
    chk("R11 no start pend", c_start - s_start, 1);
    pulse_done();
    repeat (24) @(negedge clk);
    chk("R6 ack still", c_ack - s_ack, 1);
  endtask

  task automatic t_discard();
    go_idle();
    send_cmd(1'b0, 1'b1);
    pulse_done();
    repeat (20) @(negedge clk);
    chk("R9 no ack", c_ack - s_ack, 0);
    @(negedge clk) cmd_valid = 1'b1;
    @(negedge clk) cmd_valid = 1'b0;
    low_pulse(2);
    chk("R11 no start", c_start - s_start, 1);
    low_pulse(5);
    chk("R9 abort clears", c_abort - s_abort, 1);
  endtask

  task automatic t_long_sync();
    go_idle();
    send_cmd(1'b0, 1'b0);
    low_pulse(300);
    chk("R4 sat sync", c_sync - s_sync, 1);
    chk("R3 sync aborts ack", c_abort - s_abort, 1);
    chk("R3 sync kills", c_kill - s_kill, 1);
  endtask

  task automatic t_bounds();
    go_idle();
    send_cmd(1'b0, 1'b0);
    low_pulse(127);
    chk("R5 127 abort", c_abort - s_abort, 1);
    chk("R5 127 no sync", c_sync - s_sync, 0);
    low_pulse(128);
    chk("R3 128 sync", c_sync - s_sync, 1);
    send_cmd(1'b0, 1'b0);
    low_pulse(4);
    chk("R5 4 abort", c_abort - s_abort, 2);
  endtask

  task automatic t_collision();
    go_idle();
    send_cmd(1'b0, 1'b0);
    pulse_done();
    repeat (4) @(negedge clk);
    low_pulse(20);           // overlaps own ack and runs past it
    repeat (10) @(negedge clk);
    chk("R12 no abort", c_abort - s_abort, 0);
    chk("R12 no start", c_start - s_start, 1);
    chk("R12 ack full", c_ackcyc - s_ackcyc, ACK_CYC);
    low_pulse(2);
    chk("R12 start after", c_start - s_start, 2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start_and_sync();
    t_ack();
    t_short_abort();
    t_run_abort();
    t_mem_begun();
    t_glitch();
    t_discard();
    t_long_sync();
    t_bounds();
    t_collision();
    summary_and_end();
  end
endmodule